// File: doc/BRIEF.md
# AC-link playback frame serializer

This block builds the controller-to-codec half of an AC97-style serial link. It runs entirely on the bit clock that the codec supplies. It counts out a 256-bit frame, drives the frame-start marker, and shifts the frame out one bit per clock, most significant bit first. The frame has a 16-bit header slot followed by twelve 20-bit slots. The header says which of the later slots carry data in this frame.

Seven playback sample sources and one command source feed the block. Each uses valid/ready. Ready rises on every port for one bit clock per frame, and that cycle is the load window for the next frame. A source whose valid is high in that cycle hands over its word. A source whose valid is low leaves its slot empty and untagged. Back-pressure is absolute: a source must hold valid and its data until it sees ready. Data offered outside the window waits for the next frame. One channel has two possible slots, and a select pin, sampled in the window, chooses between them.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame lasts exactly 256 bit clocks: a 16-bit slot 0 followed by slots 1 to 12 of 20 bits each. Consecutive frames follow with no gap.
- R2: `sync_out` is high for the 16 bit clocks of slot 0 and low for the other 240 of each frame.
- R3: Slot 0 is sent MSB first. Its first bit is set when any of slots 1 to 12 is tagged. The next twelve bits are the tags of slots 1 to 12 in slot order. The last three bits are zero.
- R4: Channel 0 (main left) goes in slot 3, channel 1 (main right) in slot 4, and channel 2 (modem line) in slot 5.
- R5: Channel 4 (surround left) goes in slot 7, channel 5 (surround right) in slot 8, and channel 6 (low-frequency effects) in slot 9.
- R6: Channel 3 goes in slot 6 when `flex_alt` is 0 and in slot 11 when it is 1. The value used is the one `flex_alt` has in the load window, so later changes do not affect the frame.
- R7: A sample fills the top 16 bits of its 20-bit slot MSB first, and the low four bits are zero. Any slot that is untagged, including slots 10 and 12, is sent as all zeros.
- R8: A command taken in the load window puts `cmd_addr` in slot 1 and `cmd_data` in slot 2, both 20 bits MSB first, and sets both tags.
- R9: `smp_ready` and `cmd_ready` are high together for exactly one bit clock per frame. That cycle is two bit clocks before `sync_out` rises. A word is taken only when its valid is high in that cycle.
- R10: While `rst_n` is low, `sdata_out`, `sync_out` and all ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 112 | Seven 16-bit samples, channel c in bits [16c+15:16c] |
| smp_valid | input | 7 | Per-channel sample valid |
| smp_ready | output | 7 | Per-channel ready, high in the load window |
| flex_alt | input | 1 | Slot select for channel 3: 0 = slot 6, 1 = slot 11 |
| cmd_valid | input | 1 | Command word pair valid |
| cmd_ready | output | 1 | Command ready, high in the load window |
| cmd_addr | input | 20 | Command address word for slot 1 |
| cmd_data | input | 20 | Command data word for slot 2 |
| sdata_out | output | 1 | Serial frame data, changes on the rising bit clock edge |
| sync_out | output | 1 | Frame-start marker, high during slot 0 |

## Verification
The corner cases are the switchable channel and the header. The bench moves the switchable channel between its two slots and flips the select right after the load window. A design that sampled the select late would put the sample in the wrong slot. It would also tag the wrong header bit. A frame with no valid sources must come out all zeros, with the frame-valid bit clear. A design that tagged unused slots would show stray header bits in that frame. A design that counted one slot with the wrong width would shift every later slot off its position. It would also break the 256-cycle period between sync rises and the 16-cycle sync width.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int SLOT_W    = 20;
  localparam int TAG_W     = 16;
  localparam int NUM_SLOTS = 13;
  localparam int NUM_CH    = 7;
  localparam int SLOT_IW   = $clog2(NUM_SLOTS);

  typedef logic [SLOT_IW-1:0] slot_t;

  // Fixed channel-to-slot map; channel 3 has two homes.
  function automatic slot_t home_slot(input int ch, input logic alt);
    case (ch)
      0:       home_slot = slot_t'(3);
      1:       home_slot = slot_t'(4);
      2:       home_slot = slot_t'(5);
      3:       home_slot = alt ? slot_t'(11) : slot_t'(6);
      4:       home_slot = slot_t'(7);
      5:       home_slot = slot_t'(8);
      default: home_slot = slot_t'(9);
    endcase
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int HEAD_W  = 16,
  parameter int BODY_W  = 20,
  parameter int N_SLOTS = 13,
  localparam int SIW = $clog2(N_SLOTS),
  localparam int BIW = $clog2(BODY_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [SIW-1:0] slot_idx,
  output logic [BIW-1:0] bit_idx,
  output logic           frame_last
);
  logic [SIW-1:0] slot_q;
  logic [BIW-1:0] bit_q;
  logic [BIW-1:0] last_bit;

  always_comb last_bit = (slot_q == '0) ? BIW'(HEAD_W - 1) : BIW'(BODY_W - 1);

  // Reset one bit before the frame end so the first load window follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SIW'(N_SLOTS - 1);
      bit_q  <= BIW'(BODY_W - 2);
    end else if (bit_q == last_bit) begin
      bit_q  <= '0;
      slot_q <= (slot_q == SIW'(N_SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      bit_q  <= bit_q + 1'b1;
    end
  end

  assign slot_idx   = slot_q;
  assign bit_idx    = bit_q;
  assign frame_last = (slot_q == SIW'(N_SLOTS - 1)) && (bit_q == BIW'(BODY_W - 1));
endmodule

// File: rtl/aclink_slot_packer.sv
module aclink_slot_packer import aclink_pkg::*; #(
  parameter int SMP_W = 16,
  parameter int N_CH  = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [N_CH*SMP_W-1:0] smp_data,
  input  logic [N_CH-1:0]       smp_valid,
  input  logic                  flex_alt,
  input  logic                  cmd_valid,
  input  logic [SLOT_W-1:0]     cmd_addr,
  input  logic [SLOT_W-1:0]     cmd_data,
  input  slot_t                 slot_idx,
  output logic [SLOT_W-1:0]     slot_word
);
  logic [SMP_W-1:0]     held_q [N_CH];
  logic [N_CH-1:0]      have_q;
  logic                 alt_q;
  logic                 cmd_have_q;
  logic [SLOT_W-1:0]    addr_q, data_q;
  logic [NUM_SLOTS-1:0] tag;
  logic [TAG_W-1:0]     hdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) held_q[c] <= '0;
      have_q     <= '0;
      alt_q      <= 1'b0;
      cmd_have_q <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else if (load) begin
      have_q     <= smp_valid;
      alt_q      <= flex_alt;
      cmd_have_q <= cmd_valid;
      for (int c = 0; c < N_CH; c++)
        if (smp_valid[c]) held_q[c] <= smp_data[c*SMP_W +: SMP_W];
      if (cmd_valid) begin
        addr_q <= cmd_addr;
        data_q <= cmd_data;
      end
    end
  end

  always_comb begin
    tag = '0;
    if (cmd_have_q) begin
      tag[1] = 1'b1;
      tag[2] = 1'b1;
    end
    for (int c = 0; c < N_CH; c++)
      if (have_q[c]) tag[home_slot(c, alt_q)] = 1'b1;
  end

  always_comb begin
    hdr = '0;
    hdr[TAG_W-1] = |tag[NUM_SLOTS-1:1];
    for (int n = 1; n < NUM_SLOTS; n++) hdr[TAG_W-1-n] = tag[n];
  end

  always_comb begin
    slot_word = '0;
    if (slot_idx == '0) begin
      slot_word = SLOT_W'(hdr) << (SLOT_W - TAG_W);
    end else begin
      if (cmd_have_q && slot_idx == slot_t'(1)) slot_word = addr_q;
      if (cmd_have_q && slot_idx == slot_t'(2)) slot_word = data_q;
      for (int c = 0; c < N_CH; c++)
        if (have_q[c] && home_slot(c, alt_q) == slot_idx)
          slot_word = SLOT_W'(held_q[c]) << (SLOT_W - SMP_W);
    end
  end
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer import aclink_pkg::*; #(
  parameter int SMP_W = 16,
  parameter int N_CH  = NUM_CH
) (
  input  logic                  bit_clk,
  input  logic                  rst_n,
  input  logic [N_CH*SMP_W-1:0] smp_data,
  input  logic [N_CH-1:0]       smp_valid,
  output logic [N_CH-1:0]       smp_ready,
  input  logic                  flex_alt,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [SLOT_W-1:0]     cmd_addr,
  input  logic [SLOT_W-1:0]     cmd_data,
  output logic                  sdata_out,
  output logic                  sync_out
);
  localparam int BIW = $clog2(SLOT_W);

  slot_t             slot_idx;
  logic [BIW-1:0]    bit_idx;
  logic              frame_last;
  logic [SLOT_W-1:0] cur_word;
  logic [BIW-1:0]    pick;
  logic              sdata_q, sync_q;

  aclink_frame_timer #(
    .HEAD_W(TAG_W), .BODY_W(SLOT_W), .N_SLOTS(NUM_SLOTS)
  ) u_timer (
    .clk(bit_clk), .rst_n(rst_n),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .frame_last(frame_last)
  );

  aclink_slot_packer #(.SMP_W(SMP_W), .N_CH(N_CH)) u_pack (
    .clk(bit_clk), .rst_n(rst_n), .load(frame_last),
    .smp_data(smp_data), .smp_valid(smp_valid), .flex_alt(flex_alt),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .slot_idx(slot_idx), .slot_word(cur_word)
  );

  always_comb pick = BIW'(SLOT_W - 1) - bit_idx;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      sdata_q <= cur_word[pick];
      sync_q  <= (slot_idx == '0);
    end
  end

  assign smp_ready = {N_CH{frame_last}};
  assign cmd_ready = frame_last;
  assign sdata_out = sdata_q;
  assign sync_out  = sync_q;
endmodule

// File: rtl/aclink_tx_framer_chk.sv
module aclink_tx_framer_chk #(
  parameter int N_CH = 7
) (
  input logic            bit_clk,
  input logic            rst_n,
  input logic [N_CH-1:0] smp_ready,
  input logic            cmd_ready,
  input logic            sdata_out,
  input logic            sync_out
);
  logic [4:0] sync_run;
  logic [8:0] since_rise;
  logic       prev_sync;
  logic       seen_rise;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_run   <= '0;
      since_rise <= '0;
      prev_sync  <= 1'b0;
      seen_rise  <= 1'b0;
    end else begin
      prev_sync <= sync_out;
      sync_run  <= sync_out ? sync_run + 1'b1 : '0;
      if (sync_out && !prev_sync) begin
        since_rise <= 9'd1;
        seen_rise  <= 1'b1;
      end else if (since_rise != 9'h1FF) begin
        since_rise <= since_rise + 1'b1;
      end
    end
  end

  // R1
  frame_period_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (sync_out && !prev_sync && seen_rise) |-> since_rise == 9'd256);

  // R2
  sync_width_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!sync_out && prev_sync) |-> sync_run == 5'd16);

  // R2
  sync_max_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    sync_run <= 5'd16);

  // R3
  hdr_tail_zero_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (sync_out && sync_run >= 5'd13) |-> !sdata_out);

  // R9
  ready_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (|smp_ready) |=> !(|smp_ready));

  // R9
  ready_lead_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(cmd_ready, 2));

  // R10
  reset_quiet_chk: assert property (@(posedge bit_clk)
    !rst_n |-> (!sync_out && !sdata_out && !cmd_ready && smp_ready == '0));
endmodule

bind aclink_tx_framer aclink_tx_framer_chk #(.N_CH(N_CH)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .smp_ready(smp_ready),
  .cmd_ready(cmd_ready), .sdata_out(sdata_out), .sync_out(sync_out)
);

// File: tb/aclink_tx_framer_test.sv
`timescale 1ns/1ps
module aclink_tx_framer_test;
  localparam int NCH = 7;
  localparam int NV  = 6;
  // {valid mask[6:0], flex_alt, cmd_valid, seed[15:0]}
  localparam logic [24:0] VECS [NV] = '{
    {7'h7F, 1'b0, 1'b1, 16'hA5C3},
    {7'h7F, 1'b1, 1'b0, 16'h0001},
    {7'h00, 1'b0, 1'b0, 16'h0000},
    {7'h08, 1'b1, 1'b1, 16'hFFFF},
    {7'h55, 1'b0, 1'b0, 16'h8000},
    {7'h2A, 1'b1, 1'b1, 16'h1234}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH*16-1:0] smp_data = '0;
  logic [NCH-1:0]  smp_valid = '0;
  logic [NCH-1:0]  smp_ready;
  logic            flex_alt = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [19:0]     cmd_addr = '0, cmd_data = '0;
  logic            sdata_out, sync_out;

  int n_run = 0, n_fail = 0;
  logic cap_d [256];
  logic cap_s [256];
  int   rdy_cnt;

  always #2.5 clk = ~clk;

  aclink_tx_framer uut (
    .bit_clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .flex_alt(flex_alt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .sdata_out(sdata_out), .sync_out(sync_out)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_of(input int c, input logic alt);
    int m [NCH] = '{3, 4, 5, 6, 7, 8, 9};
    if (c == 3 && alt) return 11;
    return m[c];
  endfunction

  function automatic logic [15:0] samp(input int c, input logic [15:0] seed);
    return seed + 16'(c) * 16'h1357;
  endfunction

  task automatic capture();
    rdy_cnt = 0;
    while (!sync_out) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (i > 0) @(negedge clk);
      cap_d[i] = sdata_out;
      cap_s[i] = sync_out;
      if (smp_ready != '0) rdy_cnt++;
    end
  endtask

  task automatic run_vec(input logic [24:0] v);
    logic [6:0]  mask = v[24:18];
    logic        alt  = v[17];
    logic        cv   = v[16];
    logic [15:0] seed = v[15:0];
    logic [19:0] exp_w [13];
    logic [19:0] got;
    logic [12:0] tg;
    int          sync_bad;
    string       rq;
    for (int c = 0; c < NCH; c++) smp_data[c*16 +: 16] = samp(c, seed);
    smp_valid = mask;
    flex_alt  = alt;
    cmd_valid = cv;
    cmd_addr  = {seed, 4'h9};
    cmd_data  = {~seed, 4'h6};
    @(negedge clk);
    while (smp_ready == '0) @(negedge clk);
    @(negedge clk);
    smp_valid = '0;
    cmd_valid = 1'b0;
    flex_alt  = ~alt;
    capture();
    tg = '0;
    for (int s = 0; s < 13; s++) exp_w[s] = '0;
    if (cv) begin
      tg[1] = 1'b1; tg[2] = 1'b1;
      exp_w[1] = {seed, 4'h9};
      exp_w[2] = {~seed, 4'h6};
    end
    for (int c = 0; c < NCH; c++)
      if (mask[c]) begin
        tg[slot_of(c, alt)] = 1'b1;
        exp_w[slot_of(c, alt)] = {samp(c, seed), 4'h0};
      end
    exp_w[0] = {|tg[12:1], tg[1], tg[2], tg[3], tg[4], tg[5], tg[6], tg[7],
                tg[8], tg[9], tg[10], tg[11], tg[12], 3'b000, 4'h0};
    for (int s = 0; s < 13; s++) begin
      got = '0;
      if (s == 0) for (int b = 0; b < 16; b++) got[19-b] = cap_d[b];
      else        for (int b = 0; b < 20; b++) got[19-b] = cap_d[16 + 20*(s-1) + b];
      case (s)
        0:         rq = "R3 header";
        1, 2:      rq = "R8 command slot";
        3, 4, 5:   rq = "R4 slot";
        6, 11:     rq = "R6 flex slot";
        7, 8, 9:   rq = "R5 slot";
        default:   rq = "R7 unused slot";
      endcase
      chk(got == exp_w[s], rq, $sformatf("slot %0d", s), int'(got), int'(exp_w[s]));
    end
    sync_bad = 0;
    for (int i = 0; i < 256; i++) if (cap_s[i] != (i < 16)) sync_bad++;
    chk(sync_bad == 0, "R2", "sync shape mismatches", sync_bad, 0);
    chk(rdy_cnt == 1, "R9", "ready cycles per frame", rdy_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sync_out && !sdata_out, "R10", "sync/sdata in reset", {sync_out, sdata_out}, 0);
    chk(smp_ready == '0 && !cmd_ready, "R10", "ready in reset", int'(smp_ready), 0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);
    begin
      int gap = 0;
      while (sync_out) @(negedge clk);
      while (!sync_out) @(negedge clk);
      @(negedge clk); gap = 1;
      while (!(sync_out && gap > 16)) begin @(negedge clk); gap++; end
      chk(gap == 256, "R1", "frame period", gap, 256);
    end
    // R9: valid raised mid-frame waits for the window
    begin
      int early = 0;
      while (sync_out) @(negedge clk);
      smp_data[0 +: 16] = 16'h4C2D;
      smp_valid = 7'h01;
      for (int i = 0; i < 40; i++) begin
        if (smp_ready != '0) early++;
        @(negedge clk);
      end
      chk(early == 0, "R9", "ready outside window", early, 0);
      while (smp_ready == '0) @(negedge clk);
      @(negedge clk);
      smp_valid = '0;
      capture();
      begin
        logic [19:0] g = '0;
        for (int b = 0; b < 20; b++) g[19-b] = cap_d[16 + 40 + b];
        chk(g == 20'h4C2D0, "R9", "held sample slot 3", int'(g), 20'h4C2D0);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule